// File: doc/BRIEF.md
# Smart Card Asynchronous Activation Sequencer

This block brings up one smart card slot for asynchronous operation. Software writes a settings byte whose lowest bit requests a start. The request is accepted only while the reference clock is running. The sequencer then asks for card supply power at a selectable level and waits for a supply-good indication. After that it enables the IO pull-up, drives the two auxiliary contacts from a host-supplied byte, closes the IO switch toward the host if the settings allow it, and starts the card clock.

Card clock cycles are counted. After a fixed number of them the card reset line is released high. From then on a second count measures when the card answers, that is, when the first falling edge appears on its IO line. Two programmable 16-bit limits mark a too-early answer and a missing answer. Each outcome sets a sticky status bit and pulls down an active-low interrupt unless that bit is masked. A falling edge that arrives before reset is released, but after a short blanking interval, counts as both outcomes. An abort input returns the slot to rest in one cycle.

Top module: `scAct_top`

## Requirements
- R1: A start request (settings bit 0 = 1) is accepted only in the rest state while `clkInActive` is 1. Until then the request stays pending and `settingsOut[0]` reads 1. On acceptance `settingsOut[0]` clears by itself.
- R2: After reset, after an abort, and in the rest state, `vccEn`, `vccLevel`, `cardRst`, `cardClkEn`, `ioPullEn`, `c4Out`, `c8Out` and `ioLinkEn` are all 0.
- R3: Once a start is accepted, `vccEn` is 1 and `vccLevel` equals settings bits 7:6. While `vccGood` is 0, `ioPullEn`, `c4Out`, `c8Out`, `ioLinkEn` and `cardClkEn` stay 0.
- R4: Once `vccGood` has been seen, `ioPullEn` and `cardClkEn` are 1, `c4Out` equals `auxReg[5]`, `c8Out` equals `auxReg[4]`, and `ioLinkEn` equals settings bit 5.
- R5: `cardRst` rises after exactly `RST_CYCLES` card clock cycles with `cardClkEn` high. It never goes high without the card clock.
- R6: IO falling edges during the first `BLANK_CYCLES` card clock cycles have no effect on status.
- R7: The first IO falling edge after the blanking interval but before `cardRst` rises sets status bit 6 (early) and status bit 5 (mute).
- R8: After `cardRst` rises, a first IO falling edge while the answer count is below `{earlyHi,earlyLo}` sets bit 6 only.
- R9: A first falling edge at or after the early limit and before the mute limit sets no status bit. Later edges and the mute limit are then ignored.
- R10: If the answer count reaches `{muteHi,muteLo}` with no falling edge, bit 5 is set.
- R11: Status bits are sticky and cleared by `statusClr`. `intN` is 0 exactly when some status bit is set whose `statusMask` bit is 0.
- R12: `abort` returns the sequencer to rest from any state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the card clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| abort | input | 1 | Synchronous return to rest |
| clkInActive | input | 1 | Reference clock is toggling |
| cfgWrite | input | 1 | Write strobe for settings byte |
| cfgData | input | 8 | Settings: [7:6] supply level, [5] IO switch enable, [0] start |
| auxReg | input | 8 | Auxiliary contact levels: [5] C4, [4] C8 |
| earlyHi | input | 8 | Early limit, upper byte |
| earlyLo | input | 8 | Early limit, lower byte |
| muteHi | input | 8 | Mute limit, upper byte |
| muteLo | input | 8 | Mute limit, lower byte |
| statusMask | input | 8 | Interrupt mask per status bit, 1 = masked |
| statusClr | input | 1 | Clear all status bits |
| vccGood | input | 1 | Card supply reported stable |
| ioCardIn | input | 1 | Card IO line, asynchronous |
| settingsOut | output | 8 | Settings readback |
| statusOut | output | 8 | Status: [6] early, [5] mute |
| intN | output | 1 | Active-low interrupt |
| vccEn | output | 1 | Card supply request |
| vccLevel | output | 2 | Requested supply level |
| ioPullEn | output | 1 | IO pull-up enable |
| ioLinkEn | output | 1 | IO switch to host side closed |
| c4Out | output | 1 | C4 contact level |
| c8Out | output | 1 | C8 contact level |
| cardClkEn | output | 1 | Card clock gate enable |
| cardRst | output | 1 | Card reset line |

## Verification
The hardest case to reach is a falling edge that lands after the blanking interval but before reset is released. It needs a full power-up and a precise position inside a count of thousands of cycles. The bench shortens the reset and blanking counts through parameters and counts card clock cycles at the ports. It then drives IO low at chosen offsets: inside the blanking interval, between blanking and reset, and on each side of the early and mute limits. Each offset keeps clear of the two-flop synchronizer latency, so the outcome is unambiguous.

// File: rtl/scAct_pkg.sv
package scAct_pkg;

  typedef enum logic [2:0] {
    IDLE            = 3'd0,
    POWER_UP        = 3'd1,
    CLK_RUN_PRE_RST = 3'd2,
    ATR_WAIT        = 3'd3,
    ACTIVE          = 3'd4
  } actState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startAck;
    logic cntClr;
    logic cntEn;
    logic setEarly;
    logic setMute;
  } ctrlStrb_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic startReq;
    logic fallEdge;
    logic blankDone;
    logic rstDone;
    logic beforeEarly;
    logic muteHit;
  } dpFlags_t;

  localparam int START_BIT = 0;
  localparam int IOEN_BIT  = 5;
  localparam int LVL_LSB   = 6;
  localparam int C4_BIT    = 5;
  localparam int C8_BIT    = 4;
  localparam int EARLY_BIT = 6;
  localparam int MUTE_BIT  = 5;

endpackage

// File: rtl/scAct_dp.sv
module scAct_dp
  import scAct_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RST_CYCLES   = 42100,
  parameter int BLANK_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic [7:0] cfgData,
  input  logic       clkInActive,
  input  logic [7:0] earlyHi,
  input  logic [7:0] earlyLo,
  input  logic [7:0] muteHi,
  input  logic [7:0] muteLo,
  input  logic [7:0] statusMask,
  input  logic       statusClr,
  input  logic       ioCardIn,
  input  ctrlStrb_t  strb,
  output dpFlags_t   flags,
  output logic [7:0] settingsQ,
  output logic [7:0] statusQ,
  output logic       intN
);

  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] BLANK_LIM = CNT_W'(BLANK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [SYNC_STAGES-1:0] ioSync;
  logic                   ioPrev;
  logic [CNT_W-1:0]       cycCnt;
  logic [15:0]            earlyLim;
  logic [15:0]            muteLim;

  assign earlyLim = {earlyHi, earlyLo};
  assign muteLim  = {muteHi, muteLo};

  // IO synchronizer, idle level high
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ioSync <= '1;
        else       ioSync <= ioCardIn;
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ioSync <= '1;
        else       ioSync <= {ioSync[SYNC_STAGES-2:0], ioCardIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) ioPrev <= 1'b1;
    else       ioPrev <= ioSync[SYNC_STAGES-1];

  // settings register with self-clearing start bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settingsQ <= '0;
    end else if (cfgWrite) begin
      settingsQ <= cfgData;
    end else if (strb.startAck) begin
      settingsQ[START_BIT] <= 1'b0;
    end
  end

  // card clock cycle counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (strb.cntClr) begin
      cycCnt <= '0;
    end else if (strb.cntEn && cycCnt != CNT_MAX) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      if (statusClr) statusQ <= '0;
      if (strb.setEarly) statusQ[EARLY_BIT] <= 1'b1;
      if (strb.setMute)  statusQ[MUTE_BIT]  <= 1'b1;
    end
  end

  assign intN = ~|(statusQ & ~statusMask);

  always_comb begin
    flags             = '0;
    flags.startReq    = settingsQ[START_BIT] & clkInActive;
    flags.fallEdge    = ioPrev & ~ioSync[SYNC_STAGES-1];
    flags.blankDone   = cycCnt >= BLANK_LIM;
    flags.rstDone     = cycCnt == RST_LAST;
    flags.beforeEarly = 32'(cycCnt) < 32'(earlyLim);
    flags.muteHit     = 32'(cycCnt) == 32'(muteLim);
  end

  // R1: an accepted start leaves the start bit cleared
  assert_start_selfclear_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.startAck && !cfgWrite |=> !settingsQ[START_BIT]);

  // R11: status bits hold until cleared
  assert_early_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusQ[EARLY_BIT]) && !$past(statusClr) |-> statusQ[EARLY_BIT]);

  assert_mute_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusQ[MUTE_BIT]) && !$past(statusClr) |-> statusQ[MUTE_BIT]);

endmodule

// File: rtl/scAct_ctrl.sv
module scAct_ctrl
  import scAct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       abort,
  input  logic       vccGood,
  input  dpFlags_t   flags,
  input  logic [7:0] settingsQ,
  input  logic       c4Lvl,
  input  logic       c8Lvl,
  output ctrlStrb_t  strb,
  output logic       vccEn,
  output logic [1:0] vccLevel,
  output logic       ioPullEn,
  output logic       ioLinkEn,
  output logic       c4Out,
  output logic       c8Out,
  output logic       cardClkEn,
  output logic       cardRst
);

  actState_e state, nxtState;
  logic      seenEdge;
  logic      preEdge;
  logic      postVcc;

  assign preEdge = (state == CLK_RUN_PRE_RST) && flags.fallEdge
                   && flags.blankDone && !seenEdge;

  always_comb begin
    nxtState = state;
    strb     = '0;
    unique case (state)
      IDLE: begin
        if (flags.startReq) begin
          strb.startAck = 1'b1;
          strb.cntClr   = 1'b1;
          nxtState      = POWER_UP;
        end
      end
      POWER_UP: begin
        if (vccGood) begin
          strb.cntClr = 1'b1;
          nxtState    = CLK_RUN_PRE_RST;
        end
      end
      CLK_RUN_PRE_RST: begin
        strb.cntEn = 1'b1;
        if (preEdge) begin
          strb.setEarly = 1'b1;
          strb.setMute  = 1'b1;
        end
        if (flags.rstDone) begin
          strb.cntClr = 1'b1;
          nxtState    = (seenEdge || preEdge) ? ACTIVE : ATR_WAIT;
        end
      end
      ATR_WAIT: begin
        strb.cntEn = 1'b1;
        if (flags.muteHit) begin
          strb.setMute = 1'b1;
          nxtState     = ACTIVE;
        end else if (flags.fallEdge) begin
          strb.setEarly = flags.beforeEarly;
          nxtState      = ACTIVE;
        end
      end
      ACTIVE: nxtState = ACTIVE;
      default: nxtState = IDLE;
    endcase
    if (abort) begin
      strb     = '0;
      nxtState = IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nxtState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      seenEdge <= 1'b0;
    else if (abort || strb.startAck) seenEdge <= 1'b0;
    else if (preEdge)               seenEdge <= 1'b1;
  end

  assign postVcc   = (state == CLK_RUN_PRE_RST) || (state == ATR_WAIT)
                     || (state == ACTIVE);
  assign vccEn     = (state != IDLE);
  assign vccLevel  = vccEn ? settingsQ[LVL_LSB+1:LVL_LSB] : 2'b00;
  assign ioPullEn  = postVcc;
  assign ioLinkEn  = postVcc & settingsQ[IOEN_BIT];
  assign c4Out     = postVcc & c4Lvl;
  assign c8Out     = postVcc & c8Lvl;
  assign cardClkEn = postVcc;
  assign cardRst   = (state == ATR_WAIT) || (state == ACTIVE);

  // R4: pull-up never enabled without the supply request
  assert_pullup_needs_vcc_R4: assert property (@(posedge clk) disable iff (!rstN)
    ioPullEn |-> vccEn);

  // R5: reset released only with a running card clock, after the count ends
  assert_rst_with_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> cardClkEn);

  assert_rst_after_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardRst) |-> $past(flags.rstDone));

  // R12: abort drops the slot to rest
  assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !vccEn && !cardRst && !cardClkEn);

endmodule

// File: rtl/scAct_top.sv
module scAct_top
  import scAct_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int RST_CYCLES   = 42100,
  parameter int BLANK_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       abort,
  input  logic       clkInActive,
  input  logic       cfgWrite,
  input  logic [7:0] cfgData,
  input  logic [7:0] auxReg,
  input  logic [7:0] earlyHi,
  input  logic [7:0] earlyLo,
  input  logic [7:0] muteHi,
  input  logic [7:0] muteLo,
  input  logic [7:0] statusMask,
  input  logic       statusClr,
  input  logic       vccGood,
  input  logic       ioCardIn,
  output logic [7:0] settingsOut,
  output logic [7:0] statusOut,
  output logic       intN,
  output logic       vccEn,
  output logic [1:0] vccLevel,
  output logic       ioPullEn,
  output logic       ioLinkEn,
  output logic       c4Out,
  output logic       c8Out,
  output logic       cardClkEn,
  output logic       cardRst
);

  ctrlStrb_t strb;
  dpFlags_t  flags;
  logic      unusedAux;

  assign unusedAux = ^{auxReg[7:6], auxReg[3:0]};

  scAct_dp #(
    .CNT_W       (CNT_W),
    .RST_CYCLES  (RST_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .cfgData    (cfgData),
    .clkInActive(clkInActive),
    .earlyHi    (earlyHi),
    .earlyLo    (earlyLo),
    .muteHi     (muteHi),
    .muteLo     (muteLo),
    .statusMask (statusMask),
    .statusClr  (statusClr),
    .ioCardIn   (ioCardIn),
    .strb       (strb),
    .flags      (flags),
    .settingsQ  (settingsOut),
    .statusQ    (statusOut),
    .intN       (intN)
  );

  scAct_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .abort    (abort),
    .vccGood  (vccGood),
    .flags    (flags),
    .settingsQ(settingsOut),
    .c4Lvl    (auxReg[C4_BIT]),
    .c8Lvl    (auxReg[C8_BIT]),
    .strb     (strb),
    .vccEn    (vccEn),
    .vccLevel (vccLevel),
    .ioPullEn (ioPullEn),
    .ioLinkEn (ioLinkEn),
    .c4Out    (c4Out),
    .c8Out    (c8Out),
    .cardClkEn(cardClkEn),
    .cardRst  (cardRst)
  );

endmodule

// File: tb/scAct_top_tb_top.sv
`timescale 1ns/1ps
module scAct_top_tb_top;

  localparam int RSTC  = 400;
  localparam int BLANK = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       abort = 1'b0;
  logic       clkInActive = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [7:0] cfgData = '0;
  logic [7:0] auxReg = 8'h20;
  logic [7:0] earlyHi = 8'h00;
  logic [7:0] earlyLo = 8'd40;
  logic [7:0] muteHi = 8'h00;
  logic [7:0] muteLo = 8'd120;
  logic [7:0] statusMask = '0;
  logic       statusClr = 1'b0;
  logic       vccGood = 1'b0;
  logic       ioCardIn = 1'b1;
  logic [7:0] settingsOut, statusOut;
  logic       intN, vccEn, ioPullEn, ioLinkEn, c4Out, c8Out, cardClkEn, cardRst;
  logic [1:0] vccLevel;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  scAct_top #(.RST_CYCLES(RSTC), .BLANK_CYCLES(BLANK)) dut_i (
    .clk(clk), .rstN(rstN), .abort(abort), .clkInActive(clkInActive),
    .cfgWrite(cfgWrite), .cfgData(cfgData), .auxReg(auxReg),
    .earlyHi(earlyHi), .earlyLo(earlyLo), .muteHi(muteHi), .muteLo(muteLo),
    .statusMask(statusMask), .statusClr(statusClr), .vccGood(vccGood),
    .ioCardIn(ioCardIn), .settingsOut(settingsOut), .statusOut(statusOut),
    .intN(intN), .vccEn(vccEn), .vccLevel(vccLevel), .ioPullEn(ioPullEn),
    .ioLinkEn(ioLinkEn), .c4Out(c4Out), .c8Out(c8Out), .cardClkEn(cardClkEn),
    .cardRst(cardRst)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cardPins();
    return {24'd0, vccEn, vccLevel, cardRst, cardClkEn, ioPullEn, c4Out, c8Out} | (ioLinkEn << 8);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearStatus();
    statusClr = 1'b1; tick(1); statusClr = 1'b0; tick(1);
  endtask

  task automatic doAbort();
    abort = 1'b1; tick(1); abort = 1'b0;
    vccGood = 1'b0; ioCardIn = 1'b1; tick(1);
  endtask

  // write settings, wait for supply request, report supply good, wait for clock
  task automatic launch(input logic [7:0] cfg);
    cfgData = cfg; cfgWrite = 1'b1; tick(1); cfgWrite = 1'b0;
    for (int i = 0; i < 20 && !vccEn; i++) tick(1);
    tick(2);
    vccGood = 1'b1;
    for (int i = 0; i < 20 && !cardClkEn; i++) tick(1);
  endtask

  // count card clock cycles before reset, dropping IO at given offsets
  task automatic runPre(input int glitchAt, input int glitchLen, input int edgeAt, output int n);
    n = 0;
    while (!cardRst && n < 2 * RSTC) begin
      if (n == glitchAt) ioCardIn = 1'b0;
      if (n == glitchAt + glitchLen) ioCardIn = 1'b1;
      if (n == edgeAt) ioCardIn = 1'b0;
      if (cardClkEn) n++;
      tick(1);
    end
  endtask

  task automatic runAtr(input int edgeAt, input int total);
    for (int k = 0; k < total; k++) begin
      if (k == edgeAt) ioCardIn = 1'b0;
      tick(1);
    end
  endtask

  task automatic testReset();
    check("R2", "pins after reset", cardPins(), 0);
    check("R11", "intN after reset", int'(intN), 1);
    check("R11", "status after reset", int'(statusOut), 0);
  endtask

  task automatic testStartGate();
    clkInActive = 1'b0;
    cfgData = 8'hA1; cfgWrite = 1'b1; tick(1); cfgWrite = 1'b0; tick(10);
    check("R1", "no start without clock", int'(vccEn), 0);
    check("R1", "start pending", int'(settingsOut[0]), 1);
    clkInActive = 1'b1; tick(2);
    check("R1", "start accepted", int'(vccEn), 1);
    check("R1", "start self-cleared", int'(settingsOut[0]), 0);
    check("R3", "supply level", int'(vccLevel), 2);
    tick(5);
    check("R3", "outputs held before vccGood",
          int'({ioPullEn, c4Out, c8Out, ioLinkEn, cardClkEn}), 0);
    vccGood = 1'b1; tick(2);
    check("R4", "pullup/clock after vccGood", int'({ioPullEn, cardClkEn}), 3);
    check("R4", "C4/C8 from aux", int'({c4Out, c8Out}), 2);
    check("R4", "IO link enabled", int'(ioLinkEn), 1);
    doAbort();
    check("R12", "pins after abort", cardPins(), 0);
  endtask

  task automatic testValidAtr();
    int n;
    auxReg = 8'h10;
    launch(8'h41);
    check("R4", "C4/C8 second pattern", int'({c4Out, c8Out}), 1);
    check("R4", "IO link disabled", int'(ioLinkEn), 0);
    runPre(3, 5, -1, n);
    check("R5", "cycles before reset", n, RSTC);
    check("R6", "blanked glitch ignored", int'(statusOut), 0);
    runAtr(80, 200);
    check("R9", "valid answer no status", int'(statusOut), 0);
    check("R9", "intN stays high", int'(intN), 1);
    doAbort();
  endtask

  task automatic testEarly();
    int n;
    launch(8'hE1);
    runPre(-1, 0, -1, n);
    runAtr(10, 30);
    check("R8", "early answer", int'(statusOut), 32'h40);
    check("R11", "intN on early", int'(intN), 0);
    statusMask = 8'h40; tick(1);
    check("R11", "masked intN", int'(intN), 1);
    statusMask = 8'h00; tick(1);
    check("R11", "status sticky", int'(statusOut), 32'h40);
    clearStatus();
    check("R11", "status cleared", int'(statusOut), 0);
    doAbort();
  endtask

  task automatic testMute();
    int n;
    launch(8'hA1);
    runPre(-1, 0, -1, n);
    runAtr(-1, 100);
    check("R10", "no mute before limit", int'(statusOut), 0);
    runAtr(-1, 40);
    check("R10", "mute after limit", int'(statusOut), 32'h20);
    check("R11", "intN on mute", int'(intN), 0);
    clearStatus();
    doAbort();
  endtask

  task automatic testPreRst();
    int n;
    launch(8'hA1);
    runPre(-1, 0, 200, n);
    check("R7", "pre-reset edge early+mute", int'(statusOut), 32'h60);
    check("R5", "reset still after count", n, RSTC);
    clearStatus();
    runAtr(-1, 200);
    check("R7", "no further evaluation", int'(statusOut), 0);
    abort = 1'b1; tick(1); abort = 1'b0;
    check("R12", "abort from active", cardPins(), 0);
    vccGood = 1'b0; ioCardIn = 1'b1; tick(1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testStartGate();
    testValidAtr();
    testEarly();
    testMute();
    testPreRst();
    finishRun();
  end

endmodule